// File: doc/BRIEF.md
# Daisy-Chained Interrupt Vector Arbiter

This block is the per-device part of a daisy chain that lets several identical peripherals share one service-request line and one acknowledge strobe to a CPU. Each device gathers three kinds of internal interrupt requests: receive, transmit and modem-status. Any pending request pulls the shared request line low. The CPU acknowledges with one strobe that every device sees at the same moment. A mask on the acknowledge names the request kinds that the cycle serves.

Priority comes from position in the chain. The first device gets its grant input straight from the system. Each later device takes its grant from the pass output of the device before it. A granted device that holds a pending request of an acknowledged kind claims the cycle and drives the matching vector onto the data bus. A granted device with nothing that matches passes the grant on and stays off the bus. The pass output of the last device is asserted when no device claims the cycle, so external logic can flag a cycle error. All chain-facing strobes are active-low. The bus is modelled as data plus a drive enable.

Top module: `dchain_vec_arb`

## Requirements
- R1: After reset, svc_req_n and pass_n are 1, bus_oe is 0, bus_data is 0, no request is pending, and all three vector registers hold 0.
- R2: A request input held low becomes pending after SYNC_STAGES+1 rising clock edges (3 at the default SYNC_STAGES=2). svc_req_n is 0 exactly while at least one request is pending.
- R3: While ack_n=0 and grant_n=0, and a pending request's kind has its bit set in ack_mask, the device sets bus_oe=1 and keeps pass_n=1 in the same cycle, without waiting for a clock edge.
- R4: While ack_n=0 and grant_n=0, and no pending kind is enabled in ack_mask, the device sets pass_n=0 and keeps bus_oe=0.
- R5: While ack_n=1 or grant_n=1, pass_n is 1 and bus_oe is 0, whatever is pending.
- R6: ack_mask bit 0 selects receive, bit 1 transmit and bit 2 modem. Among pending kinds enabled by the mask, receive wins over transmit, and transmit wins over modem.
- R7: When the device claims a cycle, bus_data equals the vector register of the winning kind. A write with vec_we=1 loads vec_wdata at the rising edge into the register chosen by vec_sel (0 receive, 1 transmit, 2 modem).
- R8: The pending set does not change while ack_n=0. Request changes during an acknowledge take effect only after ack_n returns to 1.
- R9: In a chain, a device whose grant comes from an earlier device's pass_n claims the cycle when the earlier device has no match. When no device matches, the last device's pass_n is 0.
- R10: bus_data is 0 whenever bus_oe is 0.
- R11: A write with vec_sel=3 changes none of the vector registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_rx_n | input | 1 | Receive request from the source, active low |
| req_tx_n | input | 1 | Transmit request from the source, active low |
| req_mdm_n | input | 1 | Modem-status request from the source, active low |
| svc_req_n | output | 1 | Shared service request to the CPU, active low |
| ack_n | input | 1 | Common acknowledge strobe, active low |
| ack_mask | input | 3 | Request kinds served by this acknowledge (bit 0 rx, bit 1 tx, bit 2 modem) |
| grant_n | input | 1 | Chain grant in, active low |
| pass_n | output | 1 | Chain grant out to the next device, active low |
| vec_we | input | 1 | Vector register write strobe |
| vec_sel | input | 2 | Vector register select for writes |
| vec_wdata | input | VEC_W | Vector write data |
| bus_oe | output | 1 | Data bus drive enable |
| bus_data | output | VEC_W | Vector placed on the data bus |

## Verification
On every cycle, assertions check the following:
- Under a live acknowledge with grant, exactly one of claim or pass is active.
- Outside a granted acknowledge, the device is quiet.
- The bus reads zero when it is not driven.
- A claimed cycle with an enabled receive request shows the receive vector.
- The pending set stays frozen across an acknowledge.
- Writes land in the selected register, and the spare select code changes nothing.

The bench scenarios cover the rest:
- The exact request latency through the synchronizer.
- The full priority order under different masks.
- Hand-off of the grant along a two-device chain.
- The cycle-error indication when no device matches.
- Requests that drop during an acknowledge coming back into effect only after release.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

   // Request kinds, in priority order (lowest index wins)
   localparam int NUM_KINDS = 3;
   localparam int KIND_W    = 2;

   typedef enum logic [KIND_W-1:0] {
      KIND_RX  = 2'd0,
      KIND_TX  = 2'd1,
      KIND_MDM = 2'd2
   } kind_e;

   localparam int MAX_SYNC = 4;

endpackage

// File: rtl/dchain_req_stage.sv
module dchain_req_stage #(
   parameter int N           = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_n,
   input  logic         hold,
   output logic [N-1:0] pend
);

   logic [N-1:0] sync_out;
   logic [N-1:0] pend_q;

   generate
      if (N < 1) begin : g_bad_n
         $error("dchain_req_stage: N must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > dchain_pkg::MAX_SYNC) begin : g_bad_sync
         $error("dchain_req_stage: SYNC_STAGES out of range");
      end

      if (SYNC_STAGES == 0) begin : g_direct
         assign sync_out = ~req_n;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][N-1:0] sr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= ~req_n;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  sr_q[k] <= sr_q[k-1];
               end
            end
         end
         assign sync_out = sr_q[SYNC_STAGES-1];
      end
   endgenerate

   // pending set updates only outside an acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (!hold) begin
         pend_q <= sync_out;
      end
   end

   assign pend = pend_q;

   // R8
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold) |-> $stable(pend_q));

endmodule

// File: rtl/dchain_prio_pick.sv
module dchain_prio_pick #(
   parameter int N = 3
) (
   input  logic [N-1:0] cand,
   output logic [N-1:0] pick_oh
);

   generate
      if (N < 1) begin : g_bad_n
         $error("dchain_prio_pick: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_pick
         if (i == 0) begin : g_top
            assign pick_oh[i] = cand[i];
         end else begin : g_rest
            assign pick_oh[i] = cand[i] & ~(|cand[i-1:0]);
         end
      end
   endgenerate

endmodule

// File: rtl/dchain_vec_bank.sv
module dchain_vec_bank #(
   parameter int N     = 3,
   parameter int W     = 8,
   parameter int SEL_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [SEL_W-1:0]    sel,
   input  logic [W-1:0]        wdata,
   input  logic [N-1:0]        pick_oh,
   output logic [N-1:0][W-1:0] vecs,
   output logic [W-1:0]        rd
);

   logic [N-1:0][W-1:0] vec_q;

   generate
      if ((1 << SEL_W) < N) begin : g_bad_sel
         $error("dchain_vec_bank: SEL_W too narrow for N");
      end
      for (genvar i = 0; i < N; i++) begin : g_reg
         logic hit;
         assign hit = we && (sel == SEL_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_q[i] <= '0;
            end else if (hit) begin
               vec_q[i] <= wdata;
            end
         end
         // R7
         vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_W'(i)) |=> (vec_q[i] == $past(wdata)));
      end
   endgenerate

   always_comb begin
      rd = '0;
      for (int i = 0; i < N; i++) begin
         if (pick_oh[i]) rd = rd | vec_q[i];
      end
   end

   assign vecs = vec_q;

   // R11
   spare_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel >= SEL_W'(N)) |=> $stable(vec_q));

endmodule

// File: rtl/dchain_vec_arb.sv
module dchain_vec_arb #(
   parameter int VEC_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_rx_n,
   input  logic                          req_tx_n,
   input  logic                          req_mdm_n,
   output logic                          svc_req_n,
   input  logic                          ack_n,
   input  logic [dchain_pkg::NUM_KINDS-1:0] ack_mask,
   input  logic                          grant_n,
   output logic                          pass_n,
   input  logic                          vec_we,
   input  logic [dchain_pkg::KIND_W-1:0] vec_sel,
   input  logic [VEC_W-1:0]              vec_wdata,
   output logic                          bus_oe,
   output logic [VEC_W-1:0]              bus_data
);

   localparam int NK = dchain_pkg::NUM_KINDS;
   localparam int SW = dchain_pkg::KIND_W;

   generate
      if (VEC_W < 1) begin : g_bad_w
         $error("dchain_vec_arb: VEC_W must be at least 1");
      end
   endgenerate

   logic [NK-1:0]            req_n_vec;
   logic [NK-1:0]            pend;
   logic [NK-1:0]            cand;
   logic [NK-1:0]            pick_oh;
   logic [NK-1:0][VEC_W-1:0] vecs;
   logic [VEC_W-1:0]         vec_rd;
   logic                     granted;
   logic                     claim;

   always_comb begin
      req_n_vec = '1;
      req_n_vec[dchain_pkg::KIND_RX]  = req_rx_n;
      req_n_vec[dchain_pkg::KIND_TX]  = req_tx_n;
      req_n_vec[dchain_pkg::KIND_MDM] = req_mdm_n;
   end

   dchain_req_stage #(.N(NK), .SYNC_STAGES(SYNC_STAGES)) u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .req_n (req_n_vec),
      .hold  (!ack_n),
      .pend  (pend)
   );

   assign cand = pend & ack_mask;

   dchain_prio_pick #(.N(NK)) u_pick (
      .cand    (cand),
      .pick_oh (pick_oh)
   );

   dchain_vec_bank #(.N(NK), .W(VEC_W), .SEL_W(SW)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (vec_we),
      .sel     (vec_sel),
      .wdata   (vec_wdata),
      .pick_oh (pick_oh),
      .vecs    (vecs),
      .rd      (vec_rd)
   );

   assign granted   = !ack_n && !grant_n;
   assign claim     = granted && (|cand);
   assign bus_oe    = claim;
   assign bus_data  = claim ? vec_rd : '0;
   assign pass_n    = !(granted && !(|cand));
   assign svc_req_n = !(|pend);

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_n || grant_n) |-> (pass_n && !bus_oe));

   // R3 R4
   one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && !grant_n) |-> (bus_oe ^ !pass_n));

   // R10
   bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_data == '0));

   // R6
   rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && pend[dchain_pkg::KIND_RX] && ack_mask[dchain_pkg::KIND_RX])
      |-> (bus_data == vecs[dchain_pkg::KIND_RX]));

endmodule

// File: tb/dchain_vec_arb_tb.sv
module dchain_vec_arb_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       ack_n = 1'b1;
   logic [2:0] ack_mask = 3'b000;
   logic       grant_n = 1'b1;

   logic a_rx_n = 1'b1, a_tx_n = 1'b1, a_mdm_n = 1'b1;
   logic b_rx_n = 1'b1, b_tx_n = 1'b1, b_mdm_n = 1'b1;
   logic a_we = 1'b0, b_we = 1'b0;
   logic [1:0] a_sel = 2'd0, b_sel = 2'd0;
   logic [W-1:0] a_wd = '0, b_wd = '0;

   logic a_svc_n, a_pass_n, a_oe;
   logic b_svc_n, b_pass_n, b_oe;
   logic [W-1:0] a_data, b_data;

   int total = 0;
   int bad = 0;

   dchain_vec_arb #(.VEC_W(W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_rx_n(a_rx_n), .req_tx_n(a_tx_n), .req_mdm_n(a_mdm_n),
      .svc_req_n(a_svc_n), .ack_n(ack_n), .ack_mask(ack_mask),
      .grant_n(grant_n), .pass_n(a_pass_n),
      .vec_we(a_we), .vec_sel(a_sel), .vec_wdata(a_wd),
      .bus_oe(a_oe), .bus_data(a_data)
   );

   dchain_vec_arb #(.VEC_W(W), .SYNC_STAGES(2)) u_dut_b (
      .clk(clk), .rst_n(rst_n),
      .req_rx_n(b_rx_n), .req_tx_n(b_tx_n), .req_mdm_n(b_mdm_n),
      .svc_req_n(b_svc_n), .ack_n(ack_n), .ack_mask(ack_mask),
      .grant_n(a_pass_n), .pass_n(b_pass_n),
      .vec_we(b_we), .vec_sel(b_sel), .vec_wdata(b_wd),
      .bus_oe(b_oe), .bus_data(b_data)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_a(input logic [1:0] s, input logic [W-1:0] d);
      @(negedge clk);
      a_we = 1'b1; a_sel = s; a_wd = d;
      @(negedge clk);
      a_we = 1'b0;
   endtask

   task automatic write_b(input logic [1:0] s, input logic [W-1:0] d);
      @(negedge clk);
      b_we = 1'b1; b_sel = s; b_wd = d;
      @(negedge clk);
      b_we = 1'b0;
   endtask

   task automatic ack_on(input logic [2:0] m);
      @(negedge clk);
      ack_mask = m; ack_n = 1'b0; grant_n = 1'b0;
      #1;
   endtask

   task automatic ack_off();
      @(negedge clk);
      ack_n = 1'b1; grant_n = 1'b1; ack_mask = 3'b000;
      #1;
   endtask

   task automatic t_reset();
      #1;
      check("R1 a svc_req_n", a_svc_n, 1);
      check("R1 a pass_n", a_pass_n, 1);
      check("R1 a bus_oe", a_oe, 0);
      check("R1 a bus_data", a_data, 0);
      check("R1 b pass_n", b_pass_n, 1);
      // vectors zero: claim rx with zero vector
      a_rx_n = 1'b0;
      cycles(4);
      ack_on(3'b001);
      check("R1 zero vector on bus", a_data, 0);
      check("R1 claimed", a_oe, 1);
      ack_off();
      a_rx_n = 1'b1;
      cycles(5);
   endtask

   task automatic t_load();
      write_a(2'd0, 8'hA1);
      write_a(2'd1, 8'hA2);
      write_a(2'd2, 8'hA3);
      write_a(2'd3, 8'hFF);
      write_b(2'd0, 8'hB1);
      write_b(2'd1, 8'hB2);
      write_b(2'd2, 8'hB3);
   endtask

   task automatic t_sync();
      @(negedge clk);
      a_tx_n = 1'b0;
      @(negedge clk);
      check("R2 after 1 edge", a_svc_n, 1);
      @(negedge clk);
      check("R2 after 2 edges", a_svc_n, 1);
      @(negedge clk);
      check("R2 after 3 edges", a_svc_n, 0);
      a_tx_n = 1'b1;
      cycles(4);
      check("R2 released", a_svc_n, 1);
   endtask

   task automatic t_prio();
      a_rx_n = 1'b0; a_tx_n = 1'b0; a_mdm_n = 1'b0;
      cycles(4);
      ack_on(3'b111);
      check("R3 claim oe", a_oe, 1);
      check("R3 claim pass", a_pass_n, 1);
      check("R6 rx wins", a_data, 8'hA1);
      check("R9 b not granted", b_oe, 0);
      ack_mask = 3'b110; #1;
      check("R6 tx over modem", a_data, 8'hA2);
      ack_mask = 3'b100; #1;
      check("R7 modem vector", a_data, 8'hA3);
      ack_mask = 3'b010; #1;
      check("R7 tx vector", a_data, 8'hA2);
      ack_off();
      a_rx_n = 1'b1; a_tx_n = 1'b1; a_mdm_n = 1'b1;
      cycles(5);
      // R11: spare select write left the vectors unchanged (A1/A2/A3 seen above)
      a_mdm_n = 1'b0;
      cycles(4);
      ack_on(3'b100);
      check("R11 modem vector kept", a_data, 8'hA3);
      ack_off();
      a_mdm_n = 1'b1;
      cycles(5);
   endtask

   task automatic t_chain();
      a_rx_n = 1'b0;
      b_tx_n = 1'b0;
      cycles(4);
      ack_on(3'b010);
      check("R4 a passes", a_pass_n, 0);
      check("R4 a off bus", a_oe, 0);
      check("R10 a data zero", a_data, 0);
      check("R9 b claims", b_oe, 1);
      check("R9 b vector", b_data, 8'hB2);
      check("R9 b no pass", b_pass_n, 1);
      ack_mask = 3'b100; #1;
      check("R9 cycle error", b_pass_n, 0);
      check("R9 b off bus", b_oe, 0);
      ack_off();
      a_rx_n = 1'b1; b_tx_n = 1'b1;
      cycles(5);
   endtask

   task automatic t_idle();
      a_rx_n = 1'b0;
      cycles(4);
      @(negedge clk);
      ack_n = 1'b0; grant_n = 1'b1; ack_mask = 3'b111; #1;
      check("R5 no grant oe", a_oe, 0);
      check("R5 no grant pass", a_pass_n, 1);
      check("R10 no grant data", a_data, 0);
      @(negedge clk);
      ack_n = 1'b1; grant_n = 1'b0; #1;
      check("R5 no ack oe", a_oe, 0);
      check("R5 no ack pass", a_pass_n, 1);
      ack_off();
      a_rx_n = 1'b1;
      cycles(5);
   endtask

   task automatic t_freeze();
      a_rx_n = 1'b0;
      cycles(4);
      ack_on(3'b001);
      a_rx_n = 1'b1;
      cycles(6);
      #1;
      check("R8 still claimed", a_oe, 1);
      check("R8 vector held", a_data, 8'hA1);
      check("R8 request held", a_svc_n, 0);
      ack_off();
      cycles(2);
      check("R8 released after ack", a_svc_n, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      t_reset();
      t_load();
      t_sync();
      t_prio();
      t_chain();
      t_idle();
      t_freeze();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule